// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for each beat of a read or write burst on a synchronous DRAM interface. A column command pulses the load strobe together with the starting column, the burst length code, the ordering (sequential or interleaved), a write flag and the write-single mode bit. From the next clock the block presents the first column. It moves one beat forward on each clock where advance is high. It flags the final beat of a finite burst. A burst ends on its last beat, on a stop pulse (burst-stop or precharge, combined by the caller), or when a new column command reloads it.

The column is 11 bits wide and holds 2048 columns per row. In finite bursts only the low log2(BL) bits move. They either wrap within the aligned block (sequential) or take start XOR beat index (interleaved). The bits above them stay fixed. Full-page mode steps linearly modulo 2048 and does not end by itself. Bank, row and the auto-precharge bit are handled elsewhere.

Top module: `sdr_colgen`

## Requirements
- R1: While reset is held and on the first cycle after it, busy and last are 0 and the column output is 0.
- R2: A load pulse makes busy 1 on the next cycle with the column equal to the start column. Load takes priority over stop and over a burst in progress.
- R3: The burst length code is 3 bits: 0, 1, 2 and 3 select 1, 2, 4 and 8 beats; any code with bit 2 set selects full page.
- R4: Sequential finite burst: beat k shows the aligned block base plus ((start mod BL) + k) mod BL. The upper bits stay fixed.
- R5: Interleaved finite burst (interleave input 1): beat k shows the block base plus ((start mod BL) XOR k).
- R6: Full page with sequential ordering: beat k shows (start + k) mod 2048. Last never asserts, and the burst runs until stop or load.
- R7: Interleave combined with a full-page code is run as an 8-beat interleaved burst.
- R8: With write-single mode set, a write load gives a 1-beat burst. A read load with the same mode keeps the coded length.
- R9: While busy with advance low (and no load or stop), the column and the beat position are held and busy stays 1.
- R10: Last is 1 exactly on the final beat of a finite burst. Advancing on that beat drops busy on the next cycle, and the column keeps its final value.
- R11: A stop pulse with no load ends a busy burst on the next cycle and leaves the column unchanged. When idle, stop has no effect.
- R12: Column commands may arrive on every clock. Each one restarts the sequence from its own start column and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Column command strobe (read or write) |
| is_write_i | input | 1 | 1 when the command is a write |
| start_col_i | input | 11 | Starting column |
| bl_code_i | input | 3 | Burst length code (R3) |
| interleave_i | input | 1 | 1 selects interleaved ordering |
| wr_single_i | input | 1 | Write-single mode bit |
| stop_i | input | 1 | Burst-stop or precharge truncation |
| adv_i | input | 1 | Advance one beat this clock |
| col_o | output | 11 | Current column address |
| busy_o | output | 1 | A burst is in progress |
| last_o | output | 1 | Current beat is the final one |

## Verification
Several properties are checked on every cycle: a load leads to the start column one cycle later, a stop or an advanced last beat clears busy, a stall keeps the column steady, the bits above the burst block stay fixed, full page steps by exactly one modulo 2048, and last never appears in full page. Other behaviour shows only in the bench's scenarios against its queue-based model: the exact sequential and interleaved orders for each length, the length chosen per code, the interleave-with-full-page fallback, the write-single split between reads and writes, and restarts by back-to-back commands.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;

  localparam int BL_CODE_W = 3;
  localparam int BL_LG_W   = 2;

  typedef struct packed {
    logic [BL_LG_W-1:0] lg;    // log2 of beats for a finite burst
    logic               full;  // linear full-page run
  } burst_cfg_t;

  // Turn the command fields into an effective burst shape.
  function automatic burst_cfg_t decode_burst(
    input logic [BL_CODE_W-1:0] code,
    input logic                 ilv,
    input logic                 is_wr,
    input logic                 wr_single
  );
    burst_cfg_t c;
    c.full = 1'b0;
    c.lg   = code[BL_LG_W-1:0];
    if (is_wr && wr_single) begin
      c.lg = '0;
    end else if (code[BL_CODE_W-1]) begin
      c.lg = '1;               // 8 beats, used when interleave forbids full page
      c.full = ~ilv;
    end
    return c;
  endfunction

  // Low-bit mask covering one finite burst block.
  function automatic logic [15:0] block_mask(input logic [BL_LG_W-1:0] lg);
    return (16'd1 << lg) - 16'd1;
  endfunction

endpackage

// File: rtl/sdr_colgen_decode.sv
module sdr_colgen_decode
  import sdr_colgen_pkg::*;
(
  input  logic [BL_CODE_W-1:0] code_i,
  input  logic                 ilv_i,
  input  logic                 is_write_i,
  input  logic                 wr_single_i,
  output burst_cfg_t           cfg_o
);
  always_comb cfg_o = decode_burst(code_i, ilv_i, is_write_i, wr_single_i);
endmodule

// File: rtl/sdr_colgen_beat.sv
module sdr_colgen_beat
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               stop_i,
  input  logic               adv_i,
  input  logic [BL_LG_W-1:0] lg_i,
  input  logic               full_i,
  output logic [COL_W-1:0]   idx_o,
  output logic               busy_o,
  output logic               last_o
);
  logic [COL_W-1:0] idx_q;
  logic             busy_q;
  logic [COL_W-1:0] final_idx_w;
  logic             last_w;

  assign final_idx_w = COL_W'(block_mask(lg_i));
  assign last_w      = busy_q & ~full_i & (idx_q == final_idx_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (stop_i) begin
        busy_q <= 1'b0;
      end else if (adv_i) begin
        if (last_w) busy_q <= 1'b0;
        else        idx_q  <= idx_q + COL_W'(1);
      end
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = busy_q;
  assign last_o = last_w;
endmodule

// File: rtl/sdr_colgen_addr.sv
module sdr_colgen_addr
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic [COL_W-1:0]   base_i,
  input  logic [COL_W-1:0]   idx_i,
  input  logic [BL_LG_W-1:0] lg_i,
  input  logic               full_i,
  input  logic               ilv_i,
  output logic [COL_W-1:0]   col_o
);
  logic [COL_W-1:0] mask_w;
  logic [COL_W-1:0] seq_w;
  logic [COL_W-1:0] ilv_w;
  logic [COL_W-1:0] page_w;

  assign mask_w = COL_W'(block_mask(lg_i));
  assign seq_w  = (base_i & ~mask_w) | ((base_i + idx_i) & mask_w);
  assign ilv_w  = (base_i & ~mask_w) | ((base_i ^ idx_i) & mask_w);
  assign page_w = base_i + idx_i;

  always_comb begin
    if (full_i)     col_o = page_w;
    else if (ilv_i) col_o = ilv_w;
    else            col_o = seq_w;
  end
endmodule

// File: rtl/sdr_colgen.sv
module sdr_colgen
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 is_write_i,
  input  logic [COL_W-1:0]     start_col_i,
  input  logic [BL_CODE_W-1:0] bl_code_i,
  input  logic                 interleave_i,
  input  logic                 wr_single_i,
  input  logic                 stop_i,
  input  logic                 adv_i,
  output logic [COL_W-1:0]     col_o,
  output logic                 busy_o,
  output logic                 last_o
);
  burst_cfg_t       cmd_cfg_w;
  logic [COL_W-1:0] base_q;
  logic [BL_LG_W-1:0] lg_q;
  logic             full_q;
  logic             ilv_q;
  logic [COL_W-1:0] idx_w;

  sdr_colgen_decode u_decode (
    .code_i      (bl_code_i),
    .ilv_i       (interleave_i),
    .is_write_i  (is_write_i),
    .wr_single_i (wr_single_i),
    .cfg_o       (cmd_cfg_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lg_q   <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= start_col_i;
      lg_q   <= cmd_cfg_w.lg;
      full_q <= cmd_cfg_w.full;
      ilv_q  <= interleave_i;
    end
  end

  sdr_colgen_beat #(.COL_W(COL_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .stop_i (stop_i),
    .adv_i  (adv_i),
    .lg_i   (lg_q),
    .full_i (full_q),
    .idx_o  (idx_w),
    .busy_o (busy_o),
    .last_o (last_o)
  );

  sdr_colgen_addr #(.COL_W(COL_W)) u_addr (
    .base_i (base_q),
    .idx_i  (idx_w),
    .lg_i   (lg_q),
    .full_i (full_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );
endmodule

// File: rtl/sdr_colgen_chk.sv
module sdr_colgen_chk #(
  parameter int COL_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             stop_i,
  input logic             adv_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic             busy_o,
  input logic             last_o,
  input logic             full_q
);
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o && col_o == $past(start_col_i)); // R2

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && stop_i && !load_i |=> !busy_o && $stable(col_o)); // R11

  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !last_o); // R6

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && full_q && adv_i && !load_i && !stop_i |=> col_o == $past(col_o) + COL_W'(1)); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !adv_i && !load_i && !stop_i |=> busy_o && $stable(col_o)); // R9

  AST_LAST_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && adv_i && !load_i |=> !busy_o && $stable(col_o)); // R10

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !full_q && !load_i |=> (col_o >> 3) == ($past(col_o) >> 3)); // R4
endmodule

bind sdr_colgen sdr_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .stop_i      (stop_i),
  .adv_i       (adv_i),
  .start_col_i (start_col_i),
  .col_o       (col_o),
  .busy_o      (busy_o),
  .last_o      (last_o),
  .full_q      (full_q)
);

// File: tb/sdr_colgen_bench.sv
module sdr_colgen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0, is_write_i = 1'b0, interleave_i = 1'b0;
  logic        wr_single_i = 1'b0, stop_i = 1'b0, adv_i = 1'b0;
  logic [10:0] start_col_i = '0;
  logic [2:0]  bl_code_i = '0;
  logic [10:0] col_o;
  logic        busy_o, last_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  bit m_busy = 0;
  int m_k = 0, m_len = 1, m_start = 0, m_col = 0;
  bit m_ilv = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  sdr_colgen u_sdr_colgen (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .is_write_i(is_write_i),
    .start_col_i(start_col_i), .bl_code_i(bl_code_i), .interleave_i(interleave_i),
    .wr_single_i(wr_single_i), .stop_i(stop_i), .adv_i(adv_i),
    .col_o(col_o), .busy_o(busy_o), .last_o(last_o)
  );

  function automatic int ref_addr(int s, int k, int len, bit ilv);
    int blk, off;
    if (len == 0) return (s + k) % 2048;
    off = s % len;
    blk = s - off;
    if (ilv) return blk + (off ^ k);
    return blk + (off + k) % len;
  endfunction

  task automatic check(string tag);
    bit m_last;
    m_last = m_busy && (m_len != 0) && (m_k == m_len - 1);
    n_cmp++;
    if (busy_o !== m_busy) begin
      n_bad++; $display("FAIL %s busy actual=%0b expected=%0b", tag, busy_o, m_busy);
    end
    n_cmp++;
    if (last_o !== m_last) begin
      n_bad++; $display("FAIL %s last actual=%0b expected=%0b", tag, last_o, m_last);
    end
    n_cmp++;
    if (col_o !== 11'(m_col)) begin
      n_bad++; $display("FAIL %s col actual=%0h expected=%0h", tag, col_o, m_col);
    end
  endtask

  // Drive one cycle of stimulus, advance the model, compare after the edge.
  task automatic cyc(bit ld, int start, int code, bit ilv, bit wr, bit ws,
                     bit stp, bit adv, string tag);
    load_i = ld; start_col_i = 11'(start); bl_code_i = 3'(code);
    interleave_i = ilv; is_write_i = wr; wr_single_i = ws;
    stop_i = stp; adv_i = adv;
    if (ld) begin
      if (wr && ws)       m_len = 1;
      else if (code < 4)  m_len = 1 << code;
      else if (ilv)       m_len = 8;
      else                m_len = 0;
      m_busy = 1; m_k = 0; m_start = start; m_ilv = ilv;
      exp_q.delete();
      for (int k = 0; k < m_len; k++) exp_q.push_back(ref_addr(start, k, m_len, ilv));
      m_col = start;
    end else if (m_busy) begin
      if (stp) m_busy = 0;
      else if (adv) begin
        if (m_len != 0 && m_k == m_len - 1) m_busy = 0;
        else begin
          m_k++;
          m_col = (m_len == 0) ? ref_addr(m_start, m_k, 0, 0) : exp_q[m_k];
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic run(int n, bit adv, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, adv, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1");

    // R4 sequential BL4 and BL8 with wrap inside block
    cyc(1, 'h2D6, 2, 0, 0, 0, 0, 1, "R4"); run(5, 1, "R4");
    cyc(1, 'h7FD, 3, 0, 0, 0, 0, 1, "R4"); run(9, 1, "R10");
    // R5 interleaved
    cyc(1, 'h135, 3, 1, 0, 0, 0, 1, "R5"); run(9, 1, "R5");
    cyc(1, 'h0AB, 1, 1, 1, 0, 0, 1, "R5"); run(3, 1, "R5");
    // R3 single beat and each code
    cyc(1, 'h3FF, 0, 0, 0, 0, 0, 1, "R3"); run(2, 1, "R3");
    cyc(1, 'h10E, 1, 0, 0, 0, 0, 1, "R3"); run(3, 1, "R3");
    // R6 full page wrapping past 2047, ended by stop
    cyc(1, 'h7FD, 7, 0, 0, 0, 0, 1, "R6"); run(6, 1, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R11"); run(2, 1, "R11");
    cyc(1, 'h400, 4, 0, 1, 0, 0, 1, "R6"); run(20, 1, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, "R11");
    // R7 interleave with full-page code
    cyc(1, 'h05A, 5, 1, 0, 0, 0, 1, "R7"); run(9, 1, "R7");
    // R8 write-single
    cyc(1, 'h222, 3, 0, 1, 1, 0, 1, "R8"); run(2, 1, "R8");
    cyc(1, 'h222, 3, 0, 0, 1, 0, 1, "R8"); run(9, 1, "R8");
    cyc(1, 'h333, 7, 0, 1, 1, 0, 1, "R8"); run(2, 1, "R8");
    // R9 stalls
    cyc(1, 'h011, 2, 0, 0, 0, 0, 0, "R9");
    run(3, 0, "R9"); run(1, 1, "R9"); run(2, 0, "R9"); run(1, 1, "R9");
    run(1, 0, "R9"); run(3, 1, "R10");
    // R11 stop when idle
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R11"); run(1, 1, "R11");
    // R12 back-to-back loads and mid-burst interruption
    cyc(1, 'h100, 3, 0, 0, 0, 0, 1, "R12");
    cyc(1, 'h205, 2, 1, 0, 0, 0, 1, "R12");
    cyc(1, 'h3F7, 3, 1, 0, 0, 0, 1, "R12");
    run(2, 1, "R12");
    cyc(1, 'h6C3, 2, 0, 0, 0, 0, 1, "R12"); run(5, 1, "R12");
    // R2 load wins over stop
    cyc(1, 'h555, 1, 0, 0, 0, 0, 1, "R2");
    cyc(1, 'h0F0, 2, 0, 0, 0, 1, 1, "R2"); run(5, 1, "R2");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule